// File: doc/BRIEF.md
# Banked ROM Mapper with Nibble RAM

This block sits between an 8-bit CPU bus with a 16-bit address and a cartridge ROM. It holds two control registers: a RAM enable flag and a 4-bit ROM bank number. CPU writes into the low 16 KiB of the address space update one of them. A single address bit picks which one; the address range does not. CPU reads in the fixed and switchable ROM windows are turned into an 18-bit physical ROM address. The ROM byte that comes back is passed through to the CPU.

The block also contains a fixed 512-entry RAM that stores 4 bits per entry. The RAM appears in an 8 KiB window and repeats across it. It can be written only after the CPU has unlocked it with the key value. The block has no RAM banking and no mode register. The ROM itself is outside the block and is reached through its address and data ports.

Top module: `nibble_bank_mapper`

## Requirements
- R1: A write (cpu_wr high at a rising clock edge) to an address in 0x0000–0x3FFF with address bit 8 equal to 0 sets the RAM enable flag when the data is exactly 0x0A. Any other data value clears the flag.
- R2: A write to an address in 0x0000–0x3FFF with address bit 8 equal to 1 loads the ROM bank register with data bits 3:0. Data bits 7:4 are discarded.
- R3: Writes to addresses at or above 0x4000 never change the RAM enable flag or the ROM bank register.
- R4: For addresses 0x0000–0x3FFF, rom_addr is address bits 13:0 with the upper 4 bits (bank field, rom_addr[17:14]) zero.
- R5: For addresses 0x4000–0x7FFF, rom_addr is {bank, address bits 13:0}. A bank register value of 0 is presented as bank 1.
- R6: The RAM window is 0xA000–0xBFFF. Address bits 8:0 select one of 512 entries, so the entries repeat across the window. A write there while RAM is enabled stores data bits 3:0 in the selected entry.
- R7: A write to the RAM window while the RAM enable flag is clear leaves the stored entry unchanged.
- R8: A read of the RAM window returns the selected entry in bits 3:0 and ones in bits 7:4 while RAM is enabled. It returns 0xFF while RAM is disabled.
- R9: After reset the RAM enable flag is clear and the ROM bank register holds 1.
- R10: While cpu_rd is high, a read in 0x0000–0x7FFF returns rom_rdata on cpu_rdata. A read of any address outside the ROM and RAM windows returns 0xFF. While cpu_rd is low, cpu_rdata is 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, sampled at the rising edge |
| cpu_rd | input | 1 | Read strobe, qualifies cpu_rdata |
| rom_addr | output | 18 | Physical ROM byte address (combinational) |
| rom_rdata | input | 8 | Byte returned by the external ROM |
| cpu_rdata | output | 8 | Read data to the CPU (combinational) |

## Verification
A wrong bank register shows up as a wrong upper field of rom_addr. It appears in the same cycle as the next read of the switchable window, and a wrong ROM byte follows on cpu_rdata. A wrong enable flag shows up at the next read of the RAM window as 0xFF in place of a nibble, or the reverse. It also shows up as a stored nibble that changed when it should not have. A corrupted RAM entry is visible only when that index, or one of its mirrors, is read back. For that reason the reference model tracks every entry it has written and compares each read against it.

// File: rtl/nbm_pkg.sv
package nbm_pkg;
   typedef enum logic [1:0] {
      RGN_ROM_FIXED = 2'd0,
      RGN_ROM_SWAP  = 2'd1,
      RGN_RAM       = 2'd2,
      RGN_NONE      = 2'd3
   } region_e;

   function automatic region_e decode_region(input logic [15:0] a);
      if (a[15:14] == 2'b00)      return RGN_ROM_FIXED;
      else if (a[15:14] == 2'b01) return RGN_ROM_SWAP;
      else if (a[15:13] == 3'b101) return RGN_RAM;
      else                        return RGN_NONE;
   endfunction
endpackage

// File: rtl/nbm_ctrl_regs.sv
module nbm_ctrl_regs #(
   parameter int BANK_W    = 4,
   parameter int DATA_W    = 8,
   parameter int RST_BANK  = 1,
   parameter int UNLOCK    = 8'h0A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic              pick_bank,
   input  logic [DATA_W-1:0] wdata,
   output logic              ram_en,
   output logic [BANK_W-1:0] bank
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ram_en <= 1'b0;
         bank   <= BANK_W'(RST_BANK);
      end else if (ctrl_we) begin
         if (pick_bank) bank   <= wdata[BANK_W-1:0];
         else           ram_en <= (wdata == DATA_W'(UNLOCK));
      end
   end

   // R3
   en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl_we && !pick_bank) |=> $stable(ram_en));
   // R3
   bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl_we && pick_bank) |=> $stable(bank));
   // R1
   en_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && !pick_bank && wdata != DATA_W'(UNLOCK)) |=> !ram_en);
endmodule

// File: rtl/nbm_rom_map.sv
module nbm_rom_map #(
   parameter int BANK_W   = 4,
   parameter int OFF_W    = 14,
   parameter bit ZERO_UP  = 1'b1,
   localparam int ROM_AW  = BANK_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              use_bank,
   input  logic [OFF_W-1:0]  offset,
   input  logic [BANK_W-1:0] bank,
   output logic [ROM_AW-1:0] rom_addr
);
   logic [BANK_W-1:0] eff_bank;

   if (ZERO_UP) begin : g_zero_up
      assign eff_bank = (bank == '0) ? BANK_W'(1) : bank;
   end else begin : g_raw
      assign eff_bank = bank;
   end

   assign rom_addr = use_bank ? {eff_bank, offset} : {{BANK_W{1'b0}}, offset};

   // R4
   fixed_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !use_bank |-> rom_addr[ROM_AW-1:OFF_W] == '0);
   // R5
   swap_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      use_bank |-> rom_addr[OFF_W-1:0] == offset);
   if (ZERO_UP) begin : g_nz_chk
      // R5
      swap_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         use_bank |-> rom_addr[ROM_AW-1:OFF_W] != '0);
   end
endmodule

// File: rtl/nbm_nibble_ram.sv
module nbm_nibble_ram #(
   parameter int DEPTH = 512,
   parameter int W     = 4,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic [W-1:0]     wnib,
   output logic [W-1:0]     rnib
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= wnib;
   end

   assign rnib = mem[idx];
endmodule

// File: rtl/nibble_bank_mapper.sv
module nibble_bank_mapper #(
   parameter int DATA_W    = 8,
   parameter int BANK_W    = 4,
   parameter int OFF_W     = 14,
   parameter int RAM_DEPTH = 512,
   parameter int RAM_W     = 4,
   parameter int SEL_BIT   = 8,
   parameter bit ZERO_UP   = 1'b1,
   localparam int ROM_AW   = BANK_W + OFF_W,
   localparam int IDX_W    = $clog2(RAM_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   output logic [ROM_AW-1:0] rom_addr,
   input  logic [DATA_W-1:0] rom_rdata,
   output logic [DATA_W-1:0] cpu_rdata
);
   import nbm_pkg::*;

   if (RAM_W > DATA_W) begin : g_bad_w
      $error("nibble width exceeds data width");
   end
   if (RAM_DEPTH != (1 << IDX_W)) begin : g_bad_depth
      $error("RAM depth must be a power of two");
   end
   if (IDX_W > 13 || SEL_BIT > 13 || OFF_W != 14) begin : g_bad_map
      $error("address map parameters do not fit the 16-bit bus");
   end

   region_e           rgn;
   logic              ram_en;
   logic [BANK_W-1:0] bank;
   logic [RAM_W-1:0]  rnib;
   logic              ctrl_we;
   logic              ram_we;

   assign rgn     = decode_region(cpu_addr);
   assign ctrl_we = cpu_wr && (rgn == RGN_ROM_FIXED);
   assign ram_we  = cpu_wr && (rgn == RGN_RAM) && ram_en;

   nbm_ctrl_regs #(
      .BANK_W (BANK_W),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_we   (ctrl_we),
      .pick_bank (cpu_addr[SEL_BIT]),
      .wdata     (cpu_wdata),
      .ram_en    (ram_en),
      .bank      (bank)
   );

   nbm_rom_map #(
      .BANK_W  (BANK_W),
      .OFF_W   (OFF_W),
      .ZERO_UP (ZERO_UP)
   ) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .use_bank (rgn != RGN_ROM_FIXED),
      .offset   (cpu_addr[OFF_W-1:0]),
      .bank     (bank),
      .rom_addr (rom_addr)
   );

   nbm_nibble_ram #(
      .DEPTH (RAM_DEPTH),
      .W     (RAM_W)
   ) u_ram (
      .clk  (clk),
      .we   (ram_we),
      .idx  (cpu_addr[IDX_W-1:0]),
      .wnib (cpu_wdata[RAM_W-1:0]),
      .rnib (rnib)
   );

   always_comb begin
      cpu_rdata = '1;
      if (cpu_rd) begin
         unique case (rgn)
            RGN_ROM_FIXED, RGN_ROM_SWAP: cpu_rdata = rom_rdata;
            RGN_RAM: if (ram_en) cpu_rdata = {{(DATA_W-RAM_W){1'b1}}, rnib};
            default: cpu_rdata = '1;
         endcase
      end
   end

   // R8
   ram_locked_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && rgn == RGN_RAM && !ram_en) |-> cpu_rdata == '1);
   // R8
   ram_high_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && rgn == RGN_RAM) |-> &cpu_rdata[DATA_W-1:RAM_W]);
   // R7
   ram_lock_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && rgn == RGN_RAM && !ram_en) |=> $stable(rnib) || !$stable(cpu_addr));
   // R10
   idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rd |-> cpu_rdata == '1);
endmodule

// File: tb/sim_nibble_bank_mapper.sv
module sim_nibble_bank_mapper;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_wr = 1'b0;
   logic        cpu_rd = 1'b0;
   logic [17:0] rom_addr;
   logic [7:0]  rom_rdata;
   logic [7:0]  cpu_rdata;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   int m_bank;
   bit m_en;
   logic [3:0] m_mem [512];
   bit m_val [512];

   always #(CLK_PERIOD/2) clk = ~clk;

   assign rom_rdata = rom_addr[7:0] ^ {2'b00, rom_addr[17:12]};

   nibble_bank_mapper u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .cpu_wr    (cpu_wr),
      .cpu_rd    (cpu_rd),
      .rom_addr  (rom_addr),
      .rom_rdata (rom_rdata),
      .cpu_rdata (cpu_rdata)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=0x%0h exp=0x%0h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
      @(negedge clk);
      cpu_wr = 1'b0;
      if (a < 16'h4000) begin
         if (a[8]) m_bank = int'(d[3:0]);
         else      m_en = (d == 8'h0A);
      end else if (a[15:13] == 3'b101 && m_en) begin
         m_mem[a[8:0]] = d[3:0];
         m_val[a[8:0]] = 1'b1;
      end
   endtask

   task automatic rd(input logic [15:0] a, input bit strobe);
      int ea;
      int ed;
      @(negedge clk);
      cpu_addr = a; cpu_rd = strobe; cpu_wr = 1'b0;
      #1;
      if (a < 16'h4000) ea = int'(a[13:0]);
      else ea = ((m_bank == 0 ? 1 : m_bank) << 14) | int'(a[13:0]);
      if (!strobe) begin
         chk(cpu_rdata == 8'hFF, "R10 idle", cpu_rdata, 8'hFF);
      end else if (a < 16'h8000) begin
         chk(rom_addr == 18'(ea), a < 16'h4000 ? "R4 addr" : "R5 addr", rom_addr, ea);
         ed = (ea & 8'hFF) ^ ((ea >> 12) & 8'h3F);
         chk(cpu_rdata == 8'(ed), "R10 rom data", cpu_rdata, ed);
      end else if (a[15:13] == 3'b101) begin
         if (!m_en) chk(cpu_rdata == 8'hFF, "R8 locked", cpu_rdata, 8'hFF);
         else if (m_val[a[8:0]])
            chk(cpu_rdata == {4'hF, m_mem[a[8:0]]}, "R6 R7 R8 ram data",
                cpu_rdata, {4'hF, m_mem[a[8:0]]});
         else chk(cpu_rdata[7:4] == 4'hF, "R8 high ones", cpu_rdata, 8'hF0);
      end else begin
         chk(cpu_rdata == 8'hFF, "R10 unmapped", cpu_rdata, 8'hFF);
      end
      cpu_rd = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      m_bank = 1; m_en = 1'b0;
      for (int i = 0; i < 512; i++) m_val[i] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9: reset state seen at ports
      rd(16'h4123, 1'b1);
      chk(rom_addr[17:14] == 4'd1, "R9 bank", rom_addr[17:14], 1);
      rd(16'hA000, 1'b1);
      chk(cpu_rdata == 8'hFF, "R9 enable", cpu_rdata, 8'hFF);
      // R7: locked write then unlock
      wr(16'hA005, 8'h07);
      wr(16'h0000, 8'h0A);                  // R1 unlock
      rd(16'hA005, 1'b1);                   // unwritten: only high ones
      wr(16'hA005, 8'hC3);                  // R6 store low nibble
      rd(16'hA005, 1'b1);
      rd(16'hBE05, 1'b1);                   // R6 mirror
      wr(16'h00FF, 8'h0B);                  // R1 wrong key locks
      wr(16'hA005, 8'h09);                  // R7 ignored
      rd(16'hA005, 1'b1);
      wr(16'h0000, 8'h0A);
      rd(16'hA005, 1'b1);
      chk(cpu_rdata == 8'hF3, "R7 entry kept", cpu_rdata, 8'hF3);
      // R2 and R5
      wr(16'h0100, 8'hF7);
      rd(16'h7FFF, 1'b1);
      wr(16'h3F00, 8'h00);
      rd(16'h4000, 1'b1);                   // R5 zero as one
      wr(16'h0100, 8'h0F);
      rd(16'h5A5A, 1'b1);
      // R3 writes above 0x3FFF
      wr(16'h4100, 8'h03);
      wr(16'h4000, 8'h00);
      wr(16'hC100, 8'h05);
      rd(16'h6000, 1'b1);
      chk(rom_addr[17:14] == 4'hF, "R3 bank kept", rom_addr[17:14], 15);
      rd(16'hA005, 1'b1);
      chk(cpu_rdata == 8'hF3, "R3 enable kept", cpu_rdata, 8'hF3);
      // R4, R10
      rd(16'h3ABC, 1'b1);
      rd(16'h0000, 1'b1);
      rd(16'h8000, 1'b1);
      rd(16'hC000, 1'b1);
      rd(16'hFFFF, 1'b1);
      rd(16'h1234, 1'b0);
      // random traffic
      for (int n = 0; n < 4000; n++) begin
         logic [15:0] a;
         logic [7:0]  d;
         a = 16'($urandom);
         d = 8'($urandom);
         case ($urandom % 6)
            0: a[15:13] = 3'b101;
            1: a[15:13] = 3'b101;
            2: a[15:14] = 2'b00;
            3: a[15:14] = 2'b01;
            default: ;
         endcase
         if ($urandom % 3 == 0) d = 8'h0A;
         if ($urandom % 2 == 0) wr(a, d);
         else rd(a, ($urandom % 8) != 0);
      end
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule